// File: doc/BRIEF.md
# Ring Oscillator Stage Dither Sequencer

This block tells a trimmable ring oscillator, one oscillator cycle at a time, how many delay stages to switch in and whether a divide-by-two follows the ring. A fixed stage count gives only coarse frequency steps. The block gets finer resolution by mixing a long count and a short count over a frame of 32 oscillator cycles. The share of long cycles in each frame sets the average period.

The 8-bit trim word has two fields. The upper 3 bits are a coarse code that selects the pair of stage counts. The lower 5 bits are a fine value equal to the number of long cycles per frame. A 5-bit phase accumulator spreads those long cycles evenly through the frame instead of grouping them together. The most significant coarse code switches to a 31-stage long ring and a 17-stage short ring with the divide-by-two enabled, which is an effective 34 stage delays. The trim word is taken in only at a frame boundary, so one frame never mixes two settings. A strobe from the oscillator advances the sequence by one cycle.

Top module: `ring_dither_seq`

## Requirements
- R1: After synchronous reset the frame position is 0 and the active trim is 8'h80 (coarse 4, fine 0). The whole first frame therefore outputs stage_cnt 19 with div2_en 0, whatever trim_in holds.
- R2: trim_in bits [7:5] are the coarse code and bits [4:0] are the fine value.
- R3: For coarse codes 0 to 6 the short count is 11 + 2*coarse and the long count is the short count plus 2. div2_en is 0 for both.
- R4: For coarse code 7 a long cycle gives stage_cnt 31 with div2_en 0, and a short cycle gives stage_cnt 17 with div2_en 1.
- R5: Within a frame, position p (0 to 31) is long exactly when floor((p+1)*f/32) > floor(p*f/32), where f is the fine value. Each frame therefore has exactly f long cycles, and position 0 is always short.
- R6: For a fine value of 16 or less, no two adjacent positions in a frame are both long.
- R7: trim_in is sampled only at the clock edge where cyc_stb is high at position 31. A change at any other time has no effect until the next frame begins.
- R8: While cyc_stb is low, stage_cnt and div2_en hold their values.
- R9: With trim 8'hDF (coarse 6, fine 31), one frame holds 31 cycles of stage_cnt 25 and one cycle of 23, and the 23 falls at position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | One pulse per oscillator cycle; advances the frame position |
| trim_in | input | 8 | Trim word: coarse code [7:5], fine value [4:0] |
| stage_cnt | output | 5 | Delay stage count for the current cycle |
| div2_en | output | 1 | Divide-by-two enable for the current cycle |

## Verification
stage_cnt and div2_en are decoded without a register from the position, the accumulator and the active trim. The code for the next position therefore appears right after the clock edge that samples cyc_stb, and a trim taken at position 31 shows up in the values for position 0 after that same edge. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, which is half a cycle after the edge that produced them. For every position of every frame it compares the outputs with a model built from the floor formula and the count mapping. It changes trim_in in the middle of each frame and checks that the outputs still follow the previously active trim.

// File: rtl/ring_dither_pkg.sv
package ring_dither_pkg;
    localparam int COARSE_W  = 3;
    localparam int FINE_W    = 5;
    localparam int STAGE_W   = 5;
    localparam int FRAME_LEN = 1 << FINE_W;

    localparam logic [COARSE_W-1:0] COARSE_TOP = '1;
    localparam logic [STAGE_W-1:0]  BASE_SHORT = STAGE_W'(11);
    localparam logic [STAGE_W-1:0]  LONG_STEP  = STAGE_W'(2);
    localparam logic [STAGE_W-1:0]  TOP_LONG   = STAGE_W'(31);
    localparam logic [STAGE_W-1:0]  TOP_SHORT  = STAGE_W'(17);

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } trim_t;

    typedef struct packed {
        logic [STAGE_W-1:0] stages;
        logic               div2;
    } ring_cfg_t;

    localparam trim_t TRIM_DEFAULT = '{coarse: COARSE_W'(4), fine: FINE_W'(0)};

    // Short ring length for the non-top coarse codes: base plus two stages per code
    function automatic logic [STAGE_W-1:0] short_count(input logic [COARSE_W-1:0] c);
        return BASE_SHORT + STAGE_W'({c, 1'b0});
    endfunction
endpackage

// File: rtl/ring_frame_seq.sv
module ring_frame_seq
    import ring_dither_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [FINE_W-1:0] fine,
    output logic [FINE_W-1:0] pos,
    output logic              is_long,
    output logic              frame_end
);
    logic [FINE_W-1:0] acc;
    logic [FINE_W:0]   sum;

    // A carry out of the phase accumulator marks a long cycle
    assign sum       = {1'b0, acc} + {1'b0, fine};
    assign is_long   = sum[FINE_W];
    assign frame_end = (pos == FINE_W'(FRAME_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            acc <= '0;
        end else if (stb) begin
            pos <= pos + 1'b1;
            acc <= frame_end ? '0 : sum[FINE_W-1:0];
        end
    end

    // Checker-only tally of long cycles in the current frame
    logic [FINE_W:0] long_seen;
    always_ff @(posedge clk) begin
        if (rst)
            long_seen <= '0;
        else if (stb)
            long_seen <= frame_end ? '0 : long_seen + {{FINE_W{1'b0}}, is_long};
    end

    assert_acc_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (pos == '0) |-> (acc == '0));

    assert_long_total_R5: assert property (@(posedge clk) disable iff (rst)
        (stb && frame_end) |-> ((long_seen + {{FINE_W{1'b0}}, is_long}) == {1'b0, fine}));

    assert_no_adjacent_long_R6: assert property (@(posedge clk) disable iff (rst)
        (stb && is_long && !frame_end && ({1'b0, fine} <= (FINE_W+1)'(FRAME_LEN / 2))) |=> !is_long);
endmodule

// File: rtl/ring_stage_map.sv
module ring_stage_map
    import ring_dither_pkg::*;
(
    input  logic [COARSE_W-1:0] coarse,
    input  logic                is_long,
    output ring_cfg_t           cfg
);
    always_comb begin
        if (coarse == COARSE_TOP) begin
            cfg.stages = is_long ? TOP_LONG : TOP_SHORT;
            cfg.div2   = !is_long;
        end else begin
            cfg.stages = short_count(coarse) + (is_long ? LONG_STEP : '0);
            cfg.div2   = 1'b0;
        end
    end
endmodule

// File: rtl/ring_dither_seq.sv
module ring_dither_seq
    import ring_dither_pkg::*;
#(
    parameter trim_t RESET_TRIM = TRIM_DEFAULT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cyc_stb,
    input  logic [COARSE_W+FINE_W-1:0] trim_in,
    output logic [STAGE_W-1:0]         stage_cnt,
    output logic                       div2_en
);
    trim_t             trim_act;
    logic [FINE_W-1:0] pos;
    logic              is_long;
    logic              frame_end;
    ring_cfg_t         cfg;

    // A new trim word is taken only as the last cycle of a frame retires
    always_ff @(posedge clk) begin
        if (rst)
            trim_act <= RESET_TRIM;
        else if (cyc_stb && frame_end)
            trim_act <= trim_t'(trim_in);
    end

    ring_frame_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .stb       (cyc_stb),
        .fine      (trim_act.fine),
        .pos       (pos),
        .is_long   (is_long),
        .frame_end (frame_end)
    );

    ring_stage_map u_map (
        .coarse  (trim_act.coarse),
        .is_long (is_long),
        .cfg     (cfg)
    );

    assign stage_cnt = cfg.stages;
    assign div2_en   = cfg.div2;

    assert_trim_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(cyc_stb && frame_end) |=> $stable(trim_act));

    assert_div2_top_short_R4: assert property (@(posedge clk) disable iff (rst)
        div2_en |-> (trim_act.coarse == COARSE_TOP && !is_long));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !cyc_stb |=> ($stable(stage_cnt) && $stable(div2_en)));
endmodule

// File: tb/sim_ring_dither_seq.sv
module sim_ring_dither_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       cyc_stb;
    logic [7:0] trim_in;
    logic [4:0] stage_cnt;
    logic       div2_en;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    ring_dither_seq u0 (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .trim_in(trim_in),
        .stage_cnt(stage_cnt), .div2_en(div2_en)
    );

    // Trim words and the short count each gives at position 0 (R3, R4)
    localparam int NV = 8;
    localparam logic [7:0] VEC_TRIM  [NV] = '{8'hDF, 8'h01, 8'h10, 8'hE5, 8'h00, 8'h2A, 8'hFF, 8'h7B};
    localparam int         VEC_SHORT [NV] = '{23, 11, 11, 17, 11, 13, 17, 17};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_long(input int f, input int p);
        return (((p + 1) * f) / 32) > ((p * f) / 32);
    endfunction

    function automatic int exp_stage(input logic [7:0] t, input int p);
        int c = int'(t[7:5]);
        bit l = exp_long(int'(t[4:0]), p);
        if (c == 7) return l ? 31 : 17;
        return 11 + 2 * c + (l ? 2 : 0);
    endfunction

    function automatic bit exp_div2(input logic [7:0] t, input int p);
        return (t[7:5] == 3'd7) && !exp_long(int'(t[4:0]), p);
    endfunction

    // One frame under trim act; next is presented late, with noise earlier (R7)
    task automatic run_frame(input logic [7:0] act, input logic [7:0] nxt, input int short0);
        int  n_long = 0;
        int  n25 = 0;
        bit  prev_long = 0;
        for (int p = 0; p < 32; p++) begin
            trim_in = (p < 20) ? ~nxt : nxt;
            chk(stage_cnt == 5'(exp_stage(act, p)),
                (act[7:5] == 3'd7) ? "R4 R5 R2 R7 stage" : "R3 R5 R2 R7 stage",
                int'(stage_cnt), exp_stage(act, p));
            chk(div2_en == exp_div2(act, p), "R4 R3 div2", int'(div2_en), int'(exp_div2(act, p)));
            if (p == 0 && short0 >= 0)
                chk(int'(stage_cnt) == short0, "R5 position 0 short", int'(stage_cnt), short0);
            if (int'(stage_cnt) > (act[7:5] == 3'd7 ? 17 : 11 + 2 * int'(act[7:5]))) begin
                n_long++;
                if (prev_long && act[4:0] <= 5'd16)
                    chk(1'b0, "R6 adjacent long", p, p + 1);
                prev_long = 1;
            end else prev_long = 0;
            if (stage_cnt == 5'd25) n25++;
            cyc_stb = 1'b1;
            @(negedge clk);
            cyc_stb = 1'b0;
        end
        chk(n_long == int'(act[4:0]), "R5 long total", n_long, int'(act[4:0]));
        if (act == 8'hDF)
            chk(n25 == 31, "R9 count of 25", n25, 31);
    endtask

    initial begin
        logic [7:0] act;
        rst = 1'b1; cyc_stb = 1'b0; trim_in = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(stage_cnt == 5'd19, "R1 reset stage", int'(stage_cnt), 19);
        chk(div2_en == 1'b0, "R1 reset div2", int'(div2_en), 0);

        // Table walk: first frame uses the reset trim (R1)
        act = 8'h80;
        for (int i = 0; i < NV; i++) begin
            run_frame(act, VEC_TRIM[i], (i == 0) ? 19 : VEC_SHORT[i-1]);
            act = VEC_TRIM[i];
        end
        run_frame(act, 8'hDF, VEC_SHORT[NV-1]);
        act = 8'hDF;

        // R9: position 0 of the coarse 6 / fine 31 frame is 23
        chk(stage_cnt == 5'd23, "R9 position 0", int'(stage_cnt), 23);

        // R8: outputs hold while no strobe arrives
        cyc_stb = 1'b1; @(negedge clk); cyc_stb = 1'b0;
        repeat (6) @(negedge clk);
        chk(stage_cnt == 5'(exp_stage(act, 1)), "R8 hold stage", int'(stage_cnt), exp_stage(act, 1));
        chk(div2_en == exp_div2(act, 1), "R8 hold div2", int'(div2_en), int'(exp_div2(act, 1)));

        // R1: reset in mid-frame restores the default trim and position 0
        repeat (5) begin cyc_stb = 1'b1; @(negedge clk); end
        cyc_stb = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        run_frame(8'h80, 8'hE5, 19);
        run_frame(8'hE5, 8'h80, 17);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule